// File: doc/BRIEF.md
# Cascaded Two-Slice Interrupt Controller

This block merges sixteen interrupt lines into one processor request using two eight-line priority slices. The second slice's winning request is fed into line 2 of the first slice, so the processor sees one request output and one acknowledge strobe. During an acknowledge the block hands back an 8-bit vector. The upper five bits of the vector come from a per-slice base. The lower three bits are the winning line, or 7 when there is no real winner at that level.

Software programs the block over a plain byte bus. Each slice has a command port and a data port, and a further port pair holds the per-line trigger-mode registers. Through these ports software sets up each slice (base, auto end-of-interrupt), masks lines, ends interrupts, rotates priority and reads the request or in-service bits. Each line can be edge or level sensitive where the fixed trigger mask allows it.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While the second slice has a deliverable request, line 2 of the first slice is latched as an edge request on every clock, and `int_req` rises once that request becomes the first slice's winner.
- R2: On an acknowledge where the first slice's winner is line 2, the second slice's winner is acknowledged as well. The vector is {second base, its line}, and both in-service bits (first slice bit 2, second slice winning bit) become set.
- R3: On an acknowledge with no deliverable request in the first slice, the vector is {first base, 3'd7} and no state changes.
- R4: On an acknowledge where the first slice picks line 2 but the second slice has no deliverable request, the vector is {second base, 3'd7} and the second slice's in-service bits are left unchanged.
- R5: On an acknowledge won by a first-slice line other than 2, the vector is {first base, line}. Under default priority the lowest-numbered pending unmasked line wins, and masked lines are never delivered.
- R6: Byte addresses 0x020/0x021 reach the first slice and 0x0A0/0x0A1 the second slice, with address bit 0 selecting the command port (0) or the data port (1). In normal mode, a data-port write sets the slice mask and a data-port read returns it. `bus_hit` is high for these addresses.
- R7: Address 0x4D0 reaches the first slice's trigger register and 0x4D1 the second's (1 = level). Written values are ANDed with 0xF8 and 0xDE respectively, and reads return the stored value.
- R8: Accesses with `bus_size` other than 0 (byte) change no state, and their reads return 0.
- R9: Any address outside the six ports reads as 0 with `bus_hit` low.
- R10: `int_req` is registered from the first slice's winner as it stood one edge before. After acknowledging the only request, `int_req` is still high after the acknowledge edge and falls after the next one.
- R11: An edge-mode line latches a request on a 0-to-1 transition and loses it when acknowledged. A level-mode line's request follows the pin and survives acknowledge.
- R12: On a command port, 0x20 clears the highest-priority in-service bit and 0x60|n clears bit n. 0x0B selects the in-service bits and 0x0A the request bits for command-port reads.
- R13: Command 0xA0 clears the highest-priority in-service bit and makes that line lowest priority. Command 0xC0|n makes line n lowest priority and changes no in-service bit.
- R14: A command-port byte with bit 4 set starts setup: it clears mask, requests, in-service bits, rotation, read select and auto end-of-interrupt. The next data writes give the base (bits 7:3), then a cascade byte that is ignored, then a mode byte only if setup bit 0 was 1. Mode bit 1 set means acknowledged lines never stay in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Interrupt lines; [7:0] first slice, [15:8] second slice; bit 2 unused (cascade) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_size | input | 2 | Access width; 0 = byte, other codes ignored |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bus_hit | output | 1 | Address falls on one of the six ports |
| inta | input | 1 | Acknowledge strobe, one clock per acknowledge |
| int_vec | output | 8 | Vector, valid while `inta` is high |
| int_req | output | 1 | Registered request to the processor |

## Verification
The bench builds the block with its default parameters. These give a 16-bit address space, port bases at 0x020, 0x0A0 and 0x4D0, and trigger masks 0xF8 and 0xDE. With this setting random addresses mostly land outside the decoded ports, and random trigger writes hit both fixed masks, including the second slice's two edge-only lines. Because the first slice's line 2 can never be level, the cascade is always an edge. That lets the bench build both spurious vectors and the rotation orderings from directed sequences, and compare random mask and pending patterns against a lowest-line function.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int unsigned    AW          = 16,
  parameter logic [AW-1:0]  MASTER_PORT = 'h020,
  parameter logic [AW-1:0]  SLAVE_PORT  = 'h0A0,
  parameter logic [AW-1:0]  TRIG_PORT   = 'h4D0,
  parameter logic [7:0]     TRIG_MASK_M = 8'hF8,
  parameter logic [7:0]     TRIG_MASK_S = 8'hDE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   irq_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_hit,
  input  logic          inta,
  output logic [7:0]    int_vec,
  output logic          int_req
);

  logic [7:0] irr [2];
  logic [7:0] imr [2];
  logic [7:0] isr [2];
  logic [7:0] lst [2];
  logic [7:0] trig [2];
  logic [2:0] padd [2];
  logic [4:0] base [2];
  logic [1:0] ist [2];
  logic       i4 [2];
  logic       aeoi [2];
  logic       rsel [2];

  function automatic logic [3:0] best(input logic [7:0] m, input logic [2:0] add);
    best = 4'd8;
    for (int p = 7; p >= 0; p--)
      if (m[3'(p) + add]) best = 4'(p);
  endfunction

  logic [3:0] pr [2];
  logic [3:0] cu [2];
  logic       ok [2];
  logic [2:0] ln [2];
  logic [7:0] lvl [2];
  logic [7:0] rise [2];
  logic [7:0] ack [2];
  logic [7:0] irr_nx [2];
  logic [7:0] isr_nx [2];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      pr[i]   = best(irr[i] & ~imr[i], padd[i]);
      cu[i]   = best(isr[i], padd[i]);
      ok[i]   = pr[i] < cu[i];
      ln[i]   = pr[i][2:0] + padd[i];
      lvl[i]  = irq_in[8*i +: 8];
      rise[i] = lvl[i] & ~lst[i];
    end
    rise[0][2] = ok[1];
    ack[0] = (inta && ok[0]) ? (8'd1 << ln[0]) : 8'd0;
    ack[1] = (inta && ok[0] && ln[0] == 3'd2 && ok[1]) ? (8'd1 << ln[1]) : 8'd0;
    for (int i = 0; i < 2; i++) begin
      irr_nx[i] = ((((irr[i] | rise[i]) & ~trig[i]) | (lvl[i] & trig[i]))) & ~(ack[i] & ~trig[i]);
      isr_nx[i] = aeoi[i] ? isr[i] : (isr[i] | ack[i]);
    end
  end

  always_comb begin
    if (!ok[0])              int_vec = {base[0], 3'd7};
    else if (ln[0] == 3'd2)  int_vec = ok[1] ? {base[1], ln[1]} : {base[1], 3'd7};
    else                     int_vec = {base[0], ln[0]};
  end

  wire byte_ok = bus_size == 2'd0;
  wire hit_m   = bus_addr[AW-1:1] == MASTER_PORT[AW-1:1];
  wire hit_s   = bus_addr[AW-1:1] == SLAVE_PORT[AW-1:1];
  wire hit_t   = bus_addr[AW-1:1] == TRIG_PORT[AW-1:1];
  wire ctl_hit = hit_m | hit_s;
  wire ws      = hit_s;
  wire a0      = bus_addr[0];
  wire wr      = bus_wr && byte_ok;

  assign bus_hit = ctl_hit | hit_t;

  logic [2:0] eo;
  logic       eo_ok;
  logic [7:0] one_w, one_e;
  assign eo    = cu[ws][2:0] + padd[ws];
  assign eo_ok = cu[ws] != 4'd8;
  assign one_w = 8'd1 << bus_wdata[2:0];
  assign one_e = 8'd1 << eo;

  always_comb begin
    bus_rdata = 8'd0;
    if (bus_rd && byte_ok) begin
      if (hit_t)        bus_rdata = trig[a0];
      else if (ctl_hit) bus_rdata = a0 ? imr[ws] : (rsel[ws] ? isr[ws] : irr[ws]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_req <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        irr[i] <= '0; imr[i] <= '0; isr[i] <= '0; lst[i] <= '0; trig[i] <= '0;
        padd[i] <= '0; base[i] <= '0; ist[i] <= '0;
        i4[i] <= 1'b0; aeoi[i] <= 1'b0; rsel[i] <= 1'b0;
      end
    end else begin
      int_req <= ok[0];
      for (int i = 0; i < 2; i++) begin
        lst[i] <= lvl[i];
        irr[i] <= irr_nx[i];
        isr[i] <= isr_nx[i];
      end
      if (wr && ctl_hit && !a0) begin
        if (bus_wdata[4]) begin
          irr[ws] <= '0; lst[ws] <= '0; imr[ws] <= '0; isr[ws] <= '0;
          padd[ws] <= '0; base[ws] <= '0; rsel[ws] <= 1'b0; aeoi[ws] <= 1'b0;
          ist[ws] <= 2'd1;
          i4[ws]  <= bus_wdata[0];
        end else if (bus_wdata[3]) begin
          if (bus_wdata[1]) rsel[ws] <= bus_wdata[0];
        end else begin
          case (bus_wdata[7:5])
            3'd1, 3'd5: if (eo_ok) begin
              isr[ws] <= isr_nx[ws] & ~one_e;
              if (bus_wdata[7]) padd[ws] <= eo + 3'd1;
            end
            3'd3: isr[ws] <= isr_nx[ws] & ~one_w;
            3'd6: padd[ws] <= bus_wdata[2:0] + 3'd1;
            3'd7: begin
              padd[ws] <= bus_wdata[2:0] + 3'd1;
              isr[ws]  <= isr_nx[ws] & ~one_w;
            end
            default: ;
          endcase
        end
      end
      if (wr && ctl_hit && a0) begin
        case (ist[ws])
          2'd0: imr[ws] <= bus_wdata;
          2'd1: begin base[ws] <= bus_wdata[7:3]; ist[ws] <= 2'd2; end
          2'd2: ist[ws] <= i4[ws] ? 2'd3 : 2'd0;
          default: begin aeoi[ws] <= bus_wdata[1]; ist[ws] <= 2'd0; end
        endcase
      end
      if (wr && hit_t)
        trig[a0] <= bus_wdata & (a0 ? TRIG_MASK_S : TRIG_MASK_M);
    end
  end

endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [7:0]    bus_rdata,
  input logic          bus_hit
);

  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> bus_rdata == 8'd0);

  p_wide_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size != 2'd0) |-> bus_rdata == 8'd0);

  p_mtrig_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 2'd0 && bus_addr == AW'('h4D0)) |-> bus_rdata[2:0] == 3'd0);

  p_strig_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_size == 2'd0 && bus_addr == AW'('h4D1)) |-> (bus_rdata & 8'h21) == 8'd0);

endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_rdata(bus_rdata), .bus_hit(bus_hit)
);

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, inta = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, int_vec;
  logic        bus_hit, int_req;

  always #2 clk = ~clk;

  cascade_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_hit(bus_hit), .inta(inta), .int_vec(int_vec),
    .int_req(int_req)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] d, v, m, pend, act;
  logic       h;

  task automatic check(input string req, input logic [15:0] a, input logic [15:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] x, input logic [1:0] sz);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = x; bus_size = sz;
    @(negedge clk);
    bus_wr = 0; bus_size = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [1:0] sz, output logic [7:0] x, output logic hh);
    @(negedge clk);
    bus_rd = 1; bus_addr = a; bus_size = sz;
    #1 x = bus_rdata; hh = bus_hit;
    @(negedge clk);
    bus_rd = 0; bus_size = 0;
  endtask

  task automatic do_ack(output logic [7:0] x);
    @(negedge clk);
    inta = 1;
    #1 x = int_vec;
    @(negedge clk);
    inta = 0;
  endtask

  task automatic setup(input logic [15:0] p, input logic [7:0] b, input logic [7:0] mode);
    wr(p, 8'h11, 0); wr(p | 16'h1, b, 0); wr(p | 16'h1, 8'h04, 0); wr(p | 16'h1, mode, 0);
  endtask

  function automatic int lowest(input logic [7:0] x);
    for (int i = 0; i < 8; i++) if (x[i]) return i;
    return 8;
  endfunction

  function automatic logic [7:0] trig_exp(input bit sl, input logic [7:0] x);
    return x & (sl ? 8'hDE : 8'hF8);
  endfunction

  function automatic bit decoded(input logic [15:0] a);
    return a[15:1] == 15'h010 || a[15:1] == 15'h050 || a[15:1] == 15'h268;
  endfunction

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    v = 8'($urandom(32'd2024));
    idle(3);
    rst_n = 1;
    idle(1);
    check("R10 reset int_req", int_req, 0);
    rd(16'h021, 0, d, h); check("R14 reset mask", d, 0);
    rd(16'h4D0, 0, d, h); check("R7 reset trigger", d, 0);

    wr(16'h021, 8'hFF, 0);
    rd(16'h021, 0, d, h); check("R6 mask readback", d, 8'hFF); check("R6 hit", h, 1);
    setup(16'h020, 8'h08, 8'h01);
    rd(16'h021, 0, d, h); check("R14 setup clears mask", d, 0);
    setup(16'h0A0, 8'h70, 8'h01);

    do_ack(v); check("R3 spurious first slice", v, 8'h0F);

    irq_in[3] = 1; irq_in[5] = 1;
    idle(2); check("R10 request raised", int_req, 1);
    do_ack(v); check("R5 lowest line wins", v, 8'h0B);
    check("R10 still high after ack edge", int_req, 1);
    idle(1); check("R10 low one edge later", int_req, 0);
    wr(16'h020, 8'h0B, 0); rd(16'h020, 0, d, h); check("R12 in-service read", d, 8'h08);
    wr(16'h020, 8'h0A, 0); rd(16'h020, 0, d, h); check("R11 edge request cleared by ack", d, 8'h20);
    wr(16'h020, 8'h20, 0);
    do_ack(v); check("R5 next line", v, 8'h0D);
    wr(16'h020, 8'h0B, 0); wr(16'h020, 8'h65, 0);
    rd(16'h020, 0, d, h); check("R12 specific end", d, 0);
    do_ack(v); check("R3 nothing left", v, 8'h0F);
    irq_in[3] = 0; irq_in[5] = 0;

    irq_in[12] = 1;
    idle(3); check("R1 cascade raises request", int_req, 1);
    do_ack(v); check("R2 cascade vector", v, 8'h74);
    rd(16'h020, 0, d, h); check("R2 first slice bit 2 in service", d, 8'h04);
    wr(16'h0A0, 8'h0B, 0); rd(16'h0A0, 0, d, h); check("R2 second slice in service", d, 8'h10);
    wr(16'h0A0, 8'h20, 0); wr(16'h020, 8'h20, 0);
    rd(16'h0A0, 0, d, h); check("R12 second slice end", d, 0);
    irq_in[12] = 0;
    idle(3); check("R1 no cascade request", int_req, 0);

    irq_in[9] = 1;
    idle(3);
    wr(16'h0A1, 8'h02, 0);
    do_ack(v); check("R4 spurious second slice", v, 8'h77);
    rd(16'h0A0, 0, d, h); check("R4 second slice untouched", d, 0);
    wr(16'h0A1, 8'h00, 0); wr(16'h020, 8'h20, 0);
    idle(3);
    do_ack(v); check("R2 unmasked cascade", v, 8'h71);
    wr(16'h0A0, 8'h20, 0); wr(16'h020, 8'h20, 0);
    irq_in[9] = 0;

    wr(16'h4D0, 8'hFF, 0); rd(16'h4D0, 0, d, h); check("R7 first trigger mask", d, 8'hF8);
    wr(16'h4D1, 8'hFF, 0); rd(16'h4D1, 0, d, h); check("R7 second trigger mask", d, 8'hDE);
    wr(16'h4D1, 8'h00, 0);
    irq_in[6] = 1;
    idle(2);
    do_ack(v); check("R11 level line vector", v, 8'h0E);
    wr(16'h020, 8'h0A, 0); rd(16'h020, 0, d, h); check("R11 level survives ack", d, 8'h40);
    wr(16'h020, 8'h20, 0);
    irq_in[6] = 0;
    idle(3);
    rd(16'h020, 0, d, h); check("R11 level follows pin", d, 0);
    check("R11 no request after release", int_req, 0);
    wr(16'h4D0, 8'h00, 0);

    irq_in[1] = 1; irq_in[4] = 1;
    idle(2);
    do_ack(v); check("R5 line 1 first", v, 8'h09);
    wr(16'h020, 8'hA0, 0);
    irq_in[1] = 0; idle(1); irq_in[1] = 1;
    idle(2);
    do_ack(v); check("R13 rotated order", v, 8'h0C);
    wr(16'h020, 8'h20, 0);
    do_ack(v); check("R13 rotated line last", v, 8'h09);
    wr(16'h020, 8'h20, 0);
    irq_in[1] = 0; irq_in[4] = 0;
    wr(16'h020, 8'hC3, 0);
    irq_in[3] = 1; irq_in[5] = 1;
    idle(2);
    do_ack(v); check("R13 set priority", v, 8'h0D);
    wr(16'h020, 8'h20, 0);
    do_ack(v); check("R13 bottom line", v, 8'h0B);
    wr(16'h020, 8'h20, 0); wr(16'h020, 8'hC7, 0);
    irq_in[3] = 0; irq_in[5] = 0;

    setup(16'h020, 8'h08, 8'h03);
    rd(16'h021, 0, d, h); check("R14 cascade byte not a mask", d, 0);
    irq_in[0] = 1;
    idle(2);
    do_ack(v); check("R14 vector after setup", v, 8'h08);
    wr(16'h020, 8'h0B, 0); rd(16'h020, 0, d, h); check("R14 auto end", d, 0);
    irq_in[0] = 0;

    wr(16'h021, 8'hFF, 2'd1);
    rd(16'h021, 0, d, h); check("R8 wide write ignored", d, 0);
    rd(16'h021, 2'd2, d, h); check("R8 wide read zero", d, 0); check("R6 hit on wide", h, 1);
    wr(16'h4D0, 8'hFF, 2'd3);
    rd(16'h4D0, 0, d, h); check("R8 wide trigger write", d, 0);
    rd(16'h022, 0, d, h); check("R9 near miss hit", h, 0);
    rd(16'h0A1, 0, d, h); check("R6 second data port hit", h, 1);

    for (int k = 0; k < 40; k++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if (!decoded(a)) begin
        rd(a, 0, d, h);
        check("R9 outside data", d, 0); check("R9 outside hit", h, 0);
      end
    end

    for (int k = 0; k < 16; k++) begin
      bit sl;
      sl = 1'($urandom);
      v = 8'($urandom);
      wr(16'h4D0 | 16'(sl), v, 0);
      rd(16'h4D0 | 16'(sl), 0, d, h);
      check("R7 random trigger", d, trig_exp(sl, v));
    end
    wr(16'h4D0, 0, 0); wr(16'h4D1, 0, 0);

    for (int r = 0; r < 20; r++) begin
      pend = 8'($urandom) & 8'hFB;
      m    = 8'($urandom) | 8'h04;
      wr(16'h021, m, 0);
      irq_in[7:0] = pend;
      idle(2);
      act = pend & ~m;
      for (int k = 0; k < 9; k++) begin
        do_ack(v);
        check("R5 random order", v, (act == 0) ? 8'h0F : 8'(8 + lowest(act)));
        if (act == 0) break;
        act[lowest(act)] = 1'b0;
      end
      irq_in[7:0] = 0;
      wr(16'h021, 0, 0);
      for (int k = 0; k < 9; k++) begin
        do_ack(v);
        if (v == 8'h0F) break;
      end
    end

    for (int k = 0; k < 8; k++) begin
      v = 8'($urandom);
      wr(16'h0A1, v, 0);
      rd(16'h0A1, 0, d, h); check("R6 second mask", d, v);
      rd(16'h021, 0, d, h); check("R6 first mask untouched", d, 0);
    end
    wr(16'h0A1, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule